// File: doc/BRIEF.md
# Per-Branch Local-History Direction Predictor

This block guesses whether a conditional branch will be taken, using only the recent outcomes of that same branch. It works in two levels. A small first-level table keeps one shift register of past outcomes for each branch slot, and a slice of the program counter selects the slot. The history read from that slot is the sole address into a second-level table of 2-bit saturating counters. The upper bit of the selected counter is the guess.

A fetch stage presents a PC on the lookup port and gets back, in the same cycle, the predicted direction and the history value used to form it. The fetch stage carries that history with the branch. When the branch resolves, the update port receives the PC, the real outcome and the carried history. The counter that the carried history addresses is trained. The outcome is shifted into the branch's own history slot.

The default history length is 10 bits, which gives 1K counters. Setting `HIST_W` to 14 gives the 16K-counter arrangement.

Top module: `lhp_local_predictor`

## Requirements
- R1: After reset every history slot reads zero and every counter holds 01, so any lookup returns `pred_hist` = 0 and `pred_taken` = 0.
- R2: The history slot is chosen by PC bits [7:2]. Two PCs that agree on those bits share a slot, whatever their other bits are.
- R3: An update replaces the addressed history with {old[HIST_W-2:0], outcome}, with the newest outcome in bit 0. No other slot changes.
- R4: A taken update raises the addressed counter by one and holds it at 3 when it is already at 3.
- R5: A not-taken update lowers the addressed counter by one and holds it at 0 when it is already at 0.
- R6: `pred_taken` is 1 exactly when the counter addressed by the branch's current history is 2 or 3.
- R7: The counter that is trained is the one addressed by `upd_hist`, the history supplied with the update. The history currently held in the slot is not used for this.
- R8: The counter address is the history alone. Branches in different slots that hold equal histories read and train the same counter.
- R9: While `upd_valid` is low, no history and no counter changes, whatever values the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pred_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_hist | output | HIST_W | History value used for this prediction |
| upd_valid | input | 1 | Update strobe for a resolved branch |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | HIST_W | History returned when this branch was predicted |

## Verification
The bench drives a counter through both rails with a run of the same outcome. A counter that wraps instead of saturating would flip its prediction after one extra step at 3 or at 0.

It trains with a history snapshot that differs from the slot's current value. A design that indexes by the live history would train the wrong counter, and a later lookup through another slot would show the wrong direction.

It uses PCs that differ only above bit 7 to check slot sharing. PCs in separate slots with equal histories show whether the PC leaks into the counter address.

Stretches of idle cycles carry random junk on the update inputs. Any write that ignores the strobe shows up in the full sweep of every slot.

// File: rtl/lhp_pkg.sv
package lhp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
    ctr_t nxt;
    if (taken) nxt = (cur == 2'b11) ? cur : cur + 2'b01;
    else       nxt = (cur == 2'b00) ? cur : cur - 2'b01;
    return nxt;
  endfunction

endpackage

// File: rtl/lhp_reset_sync.sv
module lhp_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/lhp_history_table.sv
module lhp_history_table #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int PC_LSB = 2,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   rd_pc,
  output logic [HIST_W-1:0] rd_hist,
  input  logic              wr_en,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic              wr_taken
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [ENTRIES-1:0][HIST_W-1:0] hist_q;
  logic [ENTRIES-1:0][HIST_W-1:0] hist_d;
  logic [ENTRIES-1:0]             slot_we;

  assign rd_idx  = rd_pc[PC_LSB +: IDX_W];
  assign wr_idx  = wr_pc[PC_LSB +: IDX_W];
  assign rd_hist = hist_q[rd_idx];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_comb begin
      slot_we[g] = wr_en && (wr_idx == IDX_W'(g));
      hist_d[g]  = {hist_q[g][HIST_W-2:0], wr_taken};
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)         hist_q[g] <= '0;
      else if (slot_we[g]) hist_q[g] <= hist_d[g];
    end
  end

  // R3: the written slot takes the shifted value
  a_r3_shift_in: assert property (@(posedge clk) disable iff (!rst_ni)
    wr_en |=> hist_q[$past(wr_idx)] ==
              {$past(hist_q[wr_idx][HIST_W-2:0]), $past(wr_taken)});

  // R3: a write touches at most one slot
  a_r3_one_slot: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(slot_we));

  // R9: no strobe, no history change
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(hist_q));

endmodule

// File: rtl/lhp_pattern_table.sv
module lhp_pattern_table
  import lhp_pkg::*;
#(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_t              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);

  localparam int DEPTH = 1 << HIST_W;

  logic [DEPTH-1:0][1:0] ctr_q;
  logic [DEPTH-1:0][1:0] ctr_d;

  assign rd_ctr = ctr_q[rd_idx];

  always_comb begin
    ctr_d = ctr_q;
    if (wr_en) ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ctr_q <= {DEPTH{CTR_WEAK_NT}};
    else if (wr_en) ctr_q <= ctr_d;
  end

  // R4: taken never lowers a counter
  a_r4_no_drop: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_taken) |=> ctr_q[$past(wr_idx)] >= $past(ctr_q[wr_idx]));

  // R4: saturate at the top
  a_r4_cap: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && wr_taken && ctr_q[wr_idx] == 2'b11) |=> ctr_q[$past(wr_idx)] == 2'b11);

  // R5: not-taken never raises a counter
  a_r5_no_rise: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_taken) |=> ctr_q[$past(wr_idx)] <= $past(ctr_q[wr_idx]));

  // R5: saturate at the bottom
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && !wr_taken && ctr_q[wr_idx] == 2'b00) |=> ctr_q[$past(wr_idx)] == 2'b00);

  // R9: no strobe, no counter change
  a_r9_ctr_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_en |=> $stable(ctr_q));

endmodule

// File: rtl/lhp_local_predictor.sv
module lhp_local_predictor
  import lhp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 6,
  parameter int PC_LSB = 2,
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  logic              rst_ni;
  logic [HIST_W-1:0] lvl1_hist;
  ctr_t              lvl2_ctr;

  lhp_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  lhp_history_table #(
    .PC_W   (PC_W),
    .IDX_W  (IDX_W),
    .PC_LSB (PC_LSB),
    .HIST_W (HIST_W)
  ) u_hist (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rd_pc    (pred_pc),
    .rd_hist  (lvl1_hist),
    .wr_en    (upd_valid),
    .wr_pc    (upd_pc),
    .wr_taken (upd_taken)
  );

  lhp_pattern_table #(
    .HIST_W (HIST_W)
  ) u_pht (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .rd_idx   (lvl1_hist),
    .rd_ctr   (lvl2_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_hist),
    .wr_taken (upd_taken)
  );

  assign pred_hist  = lvl1_hist;
  assign pred_taken = lvl2_ctr[1];

endmodule

// File: tb/lhp_local_predictor_test.sv
`timescale 1ns/1ps
module lhp_local_predictor_test;

  localparam int PC_W   = 32;
  localparam int HIST_W = 10;
  localparam int SLOTS  = 64;
  localparam int DEPTH  = 1 << HIST_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [PC_W-1:0]   pred_pc;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid;
  logic [PC_W-1:0]   upd_pc;
  logic              upd_taken;
  logic [HIST_W-1:0] upd_hist;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  logic [HIST_W-1:0] mh [SLOTS];
  logic [1:0]        mc [DEPTH];

  always #2 clk = ~clk;

  lhp_local_predictor uut (
    .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  function automatic int slot_of(input logic [PC_W-1:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic logic [1:0] next_ctr(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? 2'd3 : c + 2'd1;
    return (c == 2'd0) ? 2'd0 : c - 2'd1;
  endfunction

  task automatic model_update(input logic [PC_W-1:0] pc, input logic t,
                              input logic [HIST_W-1:0] h);
    int s = slot_of(pc);
    mc[h] = next_ctr(mc[h], t);
    mh[s] = {mh[s][HIST_W-2:0], t};
  endtask

  task automatic do_update(input logic [PC_W-1:0] pc, input logic t,
                           input logic [HIST_W-1:0] h);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
    @(posedge clk);
    model_update(pc, t, h);
    #1;
    upd_valid = 1'b0;
  endtask

  task automatic check(input logic [PC_W-1:0] pc, input string tag);
    logic [HIST_W-1:0] eh;
    logic et;
    @(negedge clk);
    pred_pc = pc;
    #1;
    eh = mh[slot_of(pc)];
    et = mc[eh][1];
    tests_run++;
    if (pred_hist !== eh || pred_taken !== et) begin
      tests_failed++;
      $display("FAIL %s pc=%h actual hist=%h taken=%b expected hist=%h taken=%b",
               tag, pc, pred_hist, pred_taken, eh, et);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests_run++;
    tests_failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < SLOTS; i++) mh[i] = '0;
    for (int i = 0; i < DEPTH; i++) mc[i] = 2'b01;
    rst_n = 1'b0; pred_pc = '0; upd_valid = 1'b0;
    upd_pc = '0; upd_taken = 1'b0; upd_hist = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state
    check(32'h0000_0000, "R1");
    check(32'h0000_01F4, "R1");
    check(32'hFFFF_FFFC, "R1");

    // R2 shared slot via PC bits [7:2], R3 single slot changes
    do_update(32'h0000_0100, 1'b1, '0);
    check(32'h0000_0200, "R2");
    check(32'hABCD_0000, "R2");
    check(32'h0000_0104, "R3");
    do_update(32'h0000_0004, 1'b0, '0);
    check(32'h0000_0104, "R3");

    // R4/R5/R6/R7: train counter 0 with snapshot 0 through slot 0 (live history differs)
    do_update(32'h0000_0000, 1'b1, '0);   // ctr0 01->10
    check(32'h0000_03FC, "R6");           // slot 63 still history 0
    check(32'h0000_03FC, "R7");
    do_update(32'h0000_0000, 1'b1, '0);   // 11
    do_update(32'h0000_0000, 1'b1, '0);   // stays 11
    do_update(32'h0000_0000, 1'b0, '0);   // 10
    check(32'h0000_03FC, "R4");
    do_update(32'h0000_0000, 1'b0, '0);   // 01
    check(32'h0000_03FC, "R6");
    do_update(32'h0000_0000, 1'b0, '0);   // 00
    do_update(32'h0000_0000, 1'b0, '0);   // stays 00
    do_update(32'h0000_0000, 1'b1, '0);   // 01
    check(32'h0000_03FC, "R5");
    do_update(32'h0000_0000, 1'b1, '0);   // 10
    check(32'h0000_03FC, "R5");
    check(32'h0000_03F8, "R8");           // slot 62 also history 0
    check(32'h0000_0000, "R3");

    // R9: idle cycles with junk on update inputs
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      upd_valid = 1'b0; upd_pc = $urandom; upd_taken = $urandom;
      upd_hist = HIST_W'($urandom);
    end
    for (int s = 0; s < SLOTS; s++) check(PC_W'(s << 2), "R9");

    // Random traffic, mostly faithful snapshots, some stale ones (R7)
    for (int i = 0; i < 3000; i++) begin
      logic [PC_W-1:0] pc;
      logic [HIST_W-1:0] snap;
      logic t;
      pc = $urandom & 32'h0000_0FFC;
      check(pc, "R6");
      snap = (($urandom % 5) == 0) ? HIST_W'($urandom) : mh[slot_of(pc)];
      t = (($urandom % 4) != 0);
      do_update(pc, t, snap);
    end
    for (int s = 0; s < SLOTS; s++) check(PC_W'(s << 2) | 32'h1000_0000, "R8");

    finish_run();
  end

endmodule